// File: doc/BRIEF.md
# Cascaded Serial DAC Update Controller

This block is the host-side master for a string of serial-input DACs wired in cascade, where each converter's serial output feeds the next converter's serial input. Software or a sequencer first writes one data word per converter into a small slot bank. It then raises `start`. The controller pulls the frame-select line low and sends every slot as one continuous bit stream. The word for the converter farthest from the host goes out first, so each word ends up in its own converter's input register once the stream has passed through the chain. After the frame it raises the frame select, waits a settle interval, and pulses one shared load strobe so that all converters update their outputs together. A one-cycle `done` pulse ends the sequence.

A separate clear request drives the common clear line low for a fixed number of cycles. No serial traffic takes place during a clear. The chain length, the word width, the serial-clock half period and the width of the load and clear pulses are all parameters.

Top module: `dac_chain_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `sync_n`, `sclk`, `ldac_n` and `clr_n` are all 1, and `busy` and `done` are 0.
- R2: A cycle with `ld_valid` high writes `ld_data` into slot `ld_idx`, where slot 0 belongs to the converter nearest the host. A slot keeps its value across frames. An index of N_DEV or more writes nothing.
- R3: One frame contains exactly N_DEV×WORD_W falling `sclk` edges while `sync_n` is low. Whenever `sync_n` is high, `sclk` is high.
- R4: The bit stream is slot N_DEV-1 first and slot 0 last, each word MSB first. After the load strobe, the converter at position k holds slot k.
- R5: `sdin` changes only together with a rising `sclk` edge or at frame start. It is stable whenever `sclk` is low.
- R6: Within a frame, every `sclk` level lasts exactly SCLK_HALF system cycles.
- R7: `sync_n` rises one cycle after the last rising `sclk` edge. `ldac_n` goes low only after `sync_n` has been high for at least 2×SCLK_HALF cycles, and it stays low for exactly LDAC_CYC cycles.
- R8: `done` is high for exactly one cycle, in the cycle after `ldac_n` returns high. `busy` is high from the cycle after an accepted `start` until that point.
- R9: A `start` that arrives while `busy` is high is ignored. No second frame and no second load strobe follow it.
- R10: A `clear_req` while idle drives `clr_n` low for exactly LDAC_CYC cycles. There is no frame and no load strobe, and every converter output reads zero afterwards.
- R11: A `clear_req` while `busy` is high is ignored.
- R12: Slot writes made during a frame do not change the data sent in that frame. They take effect in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | Slot write strobe |
| ld_idx | input | IDX_W | Slot index, 0 = nearest converter |
| ld_data | input | WORD_W | Word to store |
| start | input | 1 | Begin frame and update (idle only) |
| clear_req | input | 1 | Request clear pulse (idle only) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| sync_n | output | 1 | Frame select, active low |
| sclk | output | 1 | Serial clock, idles high |
| sdin | output | 1 | Serial data to first converter |
| ldac_n | output | 1 | Shared load strobe, active low |
| clr_n | output | 1 | Shared clear, active low |

## Verification
A wrong bit counter shows up at the ports within a single frame. The number of `sclk` falls is off, and every converter then holds a word that is shifted out of place when the load strobe fires. A wrong slot order or a wrong frame snapshot also appears as wrong converter contents right after the load strobe of that frame. A sequencer that enters the wrong state shows up a few cycles later, as a load strobe that fires while `sync_n` is low or too soon after it rises, a `done` that comes early or lasts too long, or a `clr_n` pulse in the middle of a frame. The bench models the converter chain behaviourally and monitors all of these on every cycle.

// File: rtl/dcc_pkg.sv
// Shared types and helpers for the cascaded DAC update controller.
// Assumes nothing beyond synthesizable SystemVerilog.
package dcc_pkg;

    // Sequencer states of the frame controller.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_TAIL,
        ST_SETTLE,
        ST_PULSE,
        ST_DONE,
        ST_CLEAR
    } dcc_state_t;

    // Width of a counter that must hold values 0..v-1, never less than 1 bit.
    function automatic int cnt_w(input int v);
        return (v > 1) ? $clog2(v) : 1;
    endfunction

endpackage

// File: rtl/dcc_word_bank.sv
// Slot bank: one register per converter, written by index.
// Presents all slots as one flat vector, slot k at bits [k*WORD_W +: WORD_W].
// Assumes indices of N_DEV or more are to be discarded.
module dcc_word_bank #(
    parameter int N_DEV  = 3,
    parameter int WORD_W = 16,
    parameter int IDX_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [WORD_W-1:0]         wr_data,
    output logic [N_DEV*WORD_W-1:0]   frame_o
);

    generate
        for (genvar g = 0; g < N_DEV; g++) begin : g_slot
            logic [WORD_W-1:0] slot_q;

            // Store the word addressed to this slot.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    slot_q <= '0;
                end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                    slot_q <= wr_data;
                end
            end

            assign frame_o[g*WORD_W +: WORD_W] = slot_q;
        end
    endgenerate

endmodule

// File: rtl/dcc_bit_timer.sv
// Half-period timer for the serial clock.
// While run is high it raises edge_o once every HALF cycles; it restarts from
// zero whenever run is low. Assumes HALF >= 1.
module dcc_bit_timer
    import dcc_pkg::*;
#(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic edge_o
);

    localparam int TW = cnt_w(HALF);

    logic [TW-1:0] tick_q;

    // Strobe in the last cycle of each half period.
    assign edge_o = run && (tick_q == TW'(HALF - 1));

    // Advance the half-period counter while running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || edge_o) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    // After an edge strobe the counter is back at zero.
    AST_TICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> (tick_q == '0))                                          // R6
        else $error("tick counter did not restart");

endmodule

// File: rtl/dcc_frame_fsm.sv
// Sequencer for one update: serial frame, settle wait, shared load strobe,
// done pulse. Also drives the clear pulse on request while idle.
// Assumes frame_i holds slot k at [k*WORD_W +: WORD_W] and that edge_i comes
// from a half-period timer running while run_o is high.
module dcc_frame_fsm
    import dcc_pkg::*;
#(
    parameter int N_DEV  = 3,
    parameter int WORD_W = 16,
    parameter int HALF   = 2,
    parameter int PULSE  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      clear_req,
    input  logic [N_DEV*WORD_W-1:0]   frame_i,
    input  logic                      edge_i,
    output logic                      run_o,
    output logic                      busy_o,
    output logic                      done_o,
    output logic                      sync_n_o,
    output logic                      sclk_o,
    output logic                      sdin_o,
    output logic                      ldac_n_o,
    output logic                      clr_n_o
);

    localparam int TOTAL    = N_DEV * WORD_W;
    localparam int SETTLE   = 2 * HALF;
    localparam int WAIT_MAX = (SETTLE > PULSE) ? SETTLE : PULSE;
    localparam int BW       = cnt_w(TOTAL);
    localparam int WW       = cnt_w(WAIT_MAX);
    localparam int FW       = cnt_w(TOTAL + 1);

    dcc_state_t        state_q;
    logic [TOTAL-1:0]  shreg_q;
    logic [BW-1:0]     bit_q;
    logic [WW-1:0]     wait_q;
    logic              sync_n_q;
    logic              sclk_q;
    logic              ldac_n_q;
    logic              clr_n_q;
    logic              done_q;

    assign run_o    = (state_q == ST_SHIFT);
    assign busy_o   = (state_q != ST_IDLE) && (state_q != ST_CLEAR);
    assign done_o   = done_q;
    assign sync_n_o = sync_n_q;
    assign sclk_o   = sclk_q;
    assign sdin_o   = shreg_q[TOTAL-1];
    assign ldac_n_o = ldac_n_q;
    assign clr_n_o  = clr_n_q;

    // Main sequencer: state, serial lines, strobes and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            shreg_q  <= '0;
            bit_q    <= '0;
            wait_q   <= '0;
            sync_n_q <= 1'b1;
            sclk_q   <= 1'b1;
            ldac_n_q <= 1'b1;
            clr_n_q  <= 1'b1;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        shreg_q  <= frame_i;
                        bit_q    <= '0;
                        sync_n_q <= 1'b0;
                        state_q  <= ST_SHIFT;
                    end else if (clear_req) begin
                        clr_n_q <= 1'b0;
                        wait_q  <= '0;
                        state_q <= ST_CLEAR;
                    end
                end
                ST_SHIFT: begin
                    if (edge_i) begin
                        if (sclk_q) begin
                            sclk_q <= 1'b0;
                        end else begin
                            sclk_q <= 1'b1;
                            if (bit_q == BW'(TOTAL - 1)) begin
                                bit_q   <= '0;
                                state_q <= ST_TAIL;
                            end else begin
                                bit_q   <= bit_q + 1'b1;
                                shreg_q <= {shreg_q[TOTAL-2:0], 1'b0};
                            end
                        end
                    end
                end
                ST_TAIL: begin
                    sync_n_q <= 1'b1;
                    wait_q   <= '0;
                    state_q  <= ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (wait_q == WW'(SETTLE - 1)) begin
                        wait_q   <= '0;
                        ldac_n_q <= 1'b0;
                        state_q  <= ST_PULSE;
                    end else begin
                        wait_q <= wait_q + 1'b1;
                    end
                end
                ST_PULSE: begin
                    if (wait_q == WW'(PULSE - 1)) begin
                        wait_q   <= '0;
                        ldac_n_q <= 1'b1;
                        state_q  <= ST_DONE;
                    end else begin
                        wait_q <= wait_q + 1'b1;
                    end
                end
                ST_DONE: begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                ST_CLEAR: begin
                    if (wait_q == WW'(PULSE - 1)) begin
                        wait_q  <= '0;
                        clr_n_q <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        wait_q <= wait_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Checker: count falling sclk edges seen inside the current frame.
    logic [FW-1:0] falls_q;
    always_ff @(posedge clk) begin
        if (!rst_n || sync_n_q) begin
            falls_q <= '0;
        end else if ($fell(sclk_q)) begin
            falls_q <= falls_q + 1'b1;
        end
    end

    AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sync_n_q |-> sclk_q)                                                // R3
        else $error("sclk low outside a frame");

    AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_n_q) |-> (falls_q == FW'(TOTAL)))                        // R3
        else $error("frame length wrong");

    AST_SDIN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_q |-> $stable(sdin_o))                                        // R5
        else $error("sdin moved while sclk low");

    AST_LDAC_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !ldac_n_q |-> (sync_n_q && sclk_q))                                 // R7
        else $error("load strobe during frame");

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q)                                                 // R8
        else $error("done longer than one cycle");

    AST_DONE_AFTER_LDAC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(ldac_n_q) && ldac_n_q)                      // R8
        else $error("done not after load strobe");

    AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n_q |-> (sync_n_q && ldac_n_q))                                // R10
        else $error("clear overlapped a frame or strobe");

endmodule

// File: rtl/dac_chain_ctrl.sv
// Top level of the cascaded serial DAC update controller.
// Ties the slot bank, the serial-clock half-period timer and the sequencer.
// Assumes a single clock domain and synchronous active-low reset; all
// outputs are registered.
module dac_chain_ctrl
    import dcc_pkg::*;
#(
    parameter int N_DEV     = 3,
    parameter int WORD_W    = 16,
    parameter int SCLK_HALF = 2,
    parameter int LDAC_CYC  = 2,
    localparam int IDX_W    = cnt_w(N_DEV)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [WORD_W-1:0] ld_data,
    input  logic              start,
    input  logic              clear_req,
    output logic              busy,
    output logic              done,
    output logic              sync_n,
    output logic              sclk,
    output logic              sdin,
    output logic              ldac_n,
    output logic              clr_n
);

    logic [N_DEV*WORD_W-1:0] frame_w;
    logic                    run_w;
    logic                    edge_w;

    dcc_word_bank #(
        .N_DEV  (N_DEV),
        .WORD_W (WORD_W),
        .IDX_W  (IDX_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ld_valid),
        .wr_idx  (ld_idx),
        .wr_data (ld_data),
        .frame_o (frame_w)
    );

    dcc_bit_timer #(
        .HALF (SCLK_HALF)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_w),
        .edge_o (edge_w)
    );

    dcc_frame_fsm #(
        .N_DEV  (N_DEV),
        .WORD_W (WORD_W),
        .HALF   (SCLK_HALF),
        .PULSE  (LDAC_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .clear_req (clear_req),
        .frame_i   (frame_w),
        .edge_i    (edge_w),
        .run_o     (run_w),
        .busy_o    (busy),
        .done_o    (done),
        .sync_n_o  (sync_n),
        .sclk_o    (sclk),
        .sdin_o    (sdin),
        .ldac_n_o  (ldac_n),
        .clr_n_o   (clr_n)
    );

    AST_BUSY_NO_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> clr_n)                                                     // R11
        else $error("clear during busy");

endmodule

// File: tb/dac_chain_ctrl_tb.sv
// Directed bench with a behavioural cascade of serial DACs on the outputs.
module dac_chain_ctrl_tb;

    localparam int N    = 3;
    localparam int W    = 16;
    localparam int DIV  = 2;
    localparam int LW   = 2;
    localparam int IW   = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_valid = 1'b0;
    logic [IW-1:0] ld_idx = '0;
    logic [W-1:0]  ld_data = '0;
    logic          start = 1'b0;
    logic          clear_req = 1'b0;
    logic busy, done, sync_n, sclk, sdin, ldac_n, clr_n;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dac_chain_ctrl #(.N_DEV(N), .WORD_W(W), .SCLK_HALF(DIV), .LDAC_CYC(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_idx(ld_idx),
        .ld_data(ld_data), .start(start), .clear_req(clear_req), .busy(busy),
        .done(done), .sync_n(sync_n), .sclk(sclk), .sdin(sdin),
        .ldac_n(ldac_n), .clr_n(clr_n)
    );

    // Behavioural chain model and protocol monitor, sampled mid-cycle.
    logic [W-1:0] dev_sr [N];
    logic [W-1:0] dev_lat [N];
    logic [W-1:0] exp_w [N];
    logic p_sync = 1, p_sclk = 1, p_sdin = 0, p_ldac = 1, p_clr = 1, p_done = 0;
    int cyc = 0, fall_cnt = 0, frames = 0, frame_bits = 0, last_tr = -1;
    int sync_rise_cyc = 0, ldac_fall_cyc = 0, ldac_rise_cyc = -10, ldac_width = 0;
    int ldac_falls = 0, dones = 0, clr_falls = 0, clr_fall_cyc = 0, clr_width = 0;
    int idle_viol = 0, sdin_viol = 0, half_viol = 0, tail_viol = 0;
    int settle_viol = 0, done_viol = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (p_sync && !sync_n) begin
                fall_cnt = 0; frames++; last_tr = -1;
            end
            if (!sync_n && p_sclk && !sclk) begin
                for (int k = N-1; k > 0; k--) dev_sr[k] = {dev_sr[k][W-2:0], dev_sr[k-1][W-1]};
                dev_sr[0] = {dev_sr[0][W-2:0], sdin};
                fall_cnt++;
            end
            if (sync_n && !sclk) idle_viol++;
            if (!sync_n && !sclk && sdin !== p_sdin) sdin_viol++;
            if (!sync_n && sclk != p_sclk) begin
                if (last_tr >= 0 && cyc - last_tr != DIV) half_viol++;
                last_tr = cyc;
            end
            if (!p_sync && sync_n) begin
                frame_bits = fall_cnt; sync_rise_cyc = cyc;
                if (cyc - last_tr != 1) tail_viol++;
            end
            if (p_ldac && !ldac_n) begin
                ldac_falls++; ldac_fall_cyc = cyc;
                if (!sync_n || cyc - sync_rise_cyc < 2*DIV) settle_viol++;
                for (int k = 0; k < N; k++) dev_lat[k] = dev_sr[k];
            end
            if (!p_ldac && ldac_n) begin
                ldac_width = cyc - ldac_fall_cyc; ldac_rise_cyc = cyc;
            end
            if (done) begin
                dones++;
                if (cyc != ldac_rise_cyc + 1 || p_done) done_viol++;
            end
            if (p_clr && !clr_n) begin clr_falls++; clr_fall_cyc = cyc; end
            if (!p_clr && clr_n) clr_width = cyc - clr_fall_cyc;
            if (!clr_n) for (int k = 0; k < N; k++) dev_lat[k] = '0;
        end
        p_sync = sync_n; p_sclk = sclk; p_sdin = sdin;
        p_ldac = ldac_n; p_clr = clr_n; p_done = done;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_slot(input int idx, input logic [W-1:0] val);
        @(negedge clk);
        ld_valid = 1'b1; ld_idx = IW'(idx); ld_data = val;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int i = 0; i < 2000 && !seen; i++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
    endtask

    // Check latched values and protocol counters after one frame.
    task automatic check_frame(input string tag, input int frames0, input int ldac0);
        chk(frames == frames0 + 1, "R3", {tag, " frame count"}, frames, frames0 + 1);
        chk(frame_bits == N*W, "R3", {tag, " sclk falls"}, frame_bits, N*W);
        for (int k = 0; k < N; k++)
            chk(dev_lat[k] == exp_w[k], "R4", $sformatf("%s device %0d", tag, k), dev_lat[k], exp_w[k]);
        chk(ldac_falls == ldac0 + 1, "R7", {tag, " strobe count"}, ldac_falls, ldac0 + 1);
        chk(ldac_width == LW, "R7", {tag, " strobe width"}, ldac_width, LW);
        chk(settle_viol == 0 && tail_viol == 0, "R7", {tag, " settle order"}, settle_viol + tail_viol, 0);
        chk(idle_viol == 0, "R3", {tag, " sclk idle"}, idle_viol, 0);
        chk(sdin_viol == 0, "R5", {tag, " sdin stability"}, sdin_viol, 0);
        chk(half_viol == 0, "R6", {tag, " half period"}, half_viol, 0);
        chk(done_viol == 0, "R8", {tag, " done timing"}, done_viol, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(sync_n && sclk && ldac_n && clr_n && !busy && !done, "R1", "outputs in reset",
            {sync_n, sclk, ldac_n, clr_n, busy, done}, 6'b111100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sync_n && sclk && ldac_n && clr_n && !busy && !done, "R1", "outputs after reset",
            {sync_n, sclk, ldac_n, clr_n, busy, done}, 6'b111100);
    endtask

    task automatic t_frame(input string tag, input logic [W-1:0] a,
                           input logic [W-1:0] b, input logic [W-1:0] c);
        int f0, l0; bit seen;
        exp_w[0] = a; exp_w[1] = b; exp_w[2] = c;
        for (int k = 0; k < N; k++) write_slot(k, exp_w[k]);
        f0 = frames; l0 = ldac_falls;
        pulse_start();
        chk(busy == 1'b1, "R8", {tag, " busy after start"}, busy, 1);
        wait_done(seen);
        chk(seen, "R8", {tag, " done seen"}, seen, 1);
        chk(!busy, "R8", {tag, " busy cleared"}, busy, 0);
        check_frame(tag, f0, l0);
    endtask

    task automatic t_start_busy();
        int f0, l0, d0; bit seen;
        f0 = frames; l0 = ldac_falls; d0 = dones;
        pulse_start();
        repeat (20) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_done(seen);
        repeat (300) @(negedge clk);
        chk(frames == f0 + 1, "R9", "frames after start while busy", frames, f0 + 1);
        chk(ldac_falls == l0 + 1, "R9", "strobes after start while busy", ldac_falls, l0 + 1);
        chk(dones == d0 + 1, "R9", "done pulses", dones, d0 + 1);
    endtask

    task automatic t_clear();
        int f0, l0, c0;
        f0 = frames; l0 = ldac_falls; c0 = clr_falls;
        @(negedge clk); clear_req = 1'b1;
        @(negedge clk); clear_req = 1'b0;
        repeat (10) @(negedge clk);
        chk(clr_falls == c0 + 1, "R10", "clear pulses", clr_falls, c0 + 1);
        chk(clr_width == LW, "R10", "clear width", clr_width, LW);
        chk(frames == f0 && ldac_falls == l0, "R10", "no frame on clear", frames - f0 + ldac_falls - l0, 0);
        for (int k = 0; k < N; k++)
            chk(dev_lat[k] == '0, "R10", $sformatf("device %0d cleared", k), dev_lat[k], 0);
    endtask

    task automatic t_clear_busy();
        int c0; bit seen;
        c0 = clr_falls;
        pulse_start();
        repeat (30) @(negedge clk);
        clear_req = 1'b1; @(negedge clk); clear_req = 1'b0;
        wait_done(seen);
        repeat (5) @(negedge clk);
        chk(clr_falls == c0, "R11", "clear ignored while busy", clr_falls, c0);
        for (int k = 0; k < N; k++)
            chk(dev_lat[k] == exp_w[k], "R11", $sformatf("device %0d kept", k), dev_lat[k], exp_w[k]);
    endtask

    task automatic t_load_busy();
        int f0, l0; bit seen;
        f0 = frames; l0 = ldac_falls;
        pulse_start();
        repeat (40) @(negedge clk);
        ld_valid = 1'b1; ld_idx = 2'd0; ld_data = 16'h5A5A; @(negedge clk);
        ld_idx = 2'd3; ld_data = 16'hFFFF; @(negedge clk);
        ld_valid = 1'b0;
        wait_done(seen);
        chk(dev_lat[0] == exp_w[0], "R12", "snapshot device 0", dev_lat[0], exp_w[0]);
        exp_w[0] = 16'h5A5A;
        f0 = frames; l0 = ldac_falls;
        pulse_start();
        wait_done(seen);
        check_frame("R12/R2 follow-up", f0, l0);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < N; k++) begin dev_sr[k] = '0; dev_lat[k] = '0; exp_w[k] = '0; end
        t_reset();
        t_frame("R4 distinct", 16'h1234, 16'hABCD, 16'h8001);
        t_frame("R4 alternating", 16'hAAAA, 16'h5555, 16'h0F0F);
        t_frame("R2 ones", 16'hFFFF, 16'h0000, 16'hFFFF);
        write_slot(3, 16'h7777);
        t_start_busy();
        chk(dev_lat[0] == 16'hFFFF && dev_lat[2] == 16'hFFFF, "R2", "out-of-range index ignored",
            dev_lat[2], 16'hFFFF);
        t_clear();
        t_clear_busy();
        t_load_busy();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule